// File: doc/BRIEF.md
# Burst Register Transfer Engine

This engine moves runs of consecutive 8-bit registers across a 16-bit word interface. A command decoder hands it one start pulse together with a start address, a count field `n` and a direction flag. A burst always covers `n+1` registers.

For a read, the engine first answers with a header word. It then fetches the registers in pairs from a register file with one-cycle read latency, and emits one data word per pair. Registers beyond the implemented range read as zero. For a write, it answers with an acknowledge word and reports how many extra words the current frame must grow by. It then takes one input word per register pair and writes the two bytes to consecutive addresses, dropping any byte aimed past the implemented range.

While any burst runs, further start pulses are ignored. During a read burst a lock flag tells the command decoder that incoming commands are being ignored.

Top module: `brst_xfer_engine`

## Requirements
- R1: One cycle after an accepted read start, `rsp_valid_o` pulses with header word {3'b011, start address[4:0], n[7:0]} (bits 15:13, 12:8, 7:0).
- R2: A read then emits ceil((n+1)/2) data words in address order, three cycles apart. Word k carries register a+2k in bits 15:8 and register a+2k+1 in bits 7:0.
- R3: When n+1 is odd, bits 7:0 of the final read data word are zero.
- R4: Any register at address NUM_REGS or above reads as zero, and no `rf_re_o` is issued for such an address.
- R5: `cmd_lock_o` is high from the cycle after a read start until the last data word has been sent, and low during write bursts. A start pulse that arrives while `busy_o` is high produces no response and no register access.
- R6: One cycle after an accepted write start, `rsp_valid_o` pulses with acknowledge word {3'b010, start address[4:0], n[7:0]}.
- R7: From the cycle after a write start until the burst ends, `frame_ext_o` equals n>>1 (integer n/2). It is zero at all other times.
- R8: Each input word accepted by `wr_word_valid_i` during a write burst writes bits 15:8 to address a+2k and then bits 7:0 to address a+2k+1, each with a single-cycle `rf_we_o` pulse.
- R9: When n+1 is odd, bits 7:0 of the last write word are not written anywhere.
- R10: No `rf_we_o` pulse is ever issued for an address at or above NUM_REGS; such bytes are discarded.
- R11: After reset, `rsp_valid_o`, `busy_o`, `cmd_lock_o`, `rf_we_o`, `rf_re_o` are low and `frame_ext_o` is zero.
- R12: `busy_o` is high from the cycle after an accepted start until the burst completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start_i | input | 1 | Start pulse from the command decoder |
| cmd_write_i | input | 1 | 1 = burst write, 0 = burst read |
| cmd_addr_i | input | 5 | Start register address |
| cmd_cnt_i | input | 8 | Count field n (burst covers n+1 registers) |
| wr_word_valid_i | input | 1 | Write data word present |
| wr_word_i | input | 16 | Write data word, two register bytes |
| rsp_valid_o | output | 1 | Response word valid (one cycle) |
| rsp_word_o | output | 16 | Header, acknowledge or read data word |
| frame_ext_o | output | 8 | Extra words the frame needs for a write burst |
| busy_o | output | 1 | Burst in progress |
| cmd_lock_o | output | 1 | Read burst running, new commands ignored |
| rf_addr_o | output | 5 | Register file address |
| rf_re_o | output | 1 | Register file read strobe (data next cycle) |
| rf_we_o | output | 1 | Register file write strobe |
| rf_wdata_o | output | 8 | Register file write data |
| rf_rdata_i | input | 8 | Register file read data |

## Verification
Two things can meet in one cycle: a new start pulse, and the final word of a burst as the engine returns to idle. The bench holds a spurious start high through the whole of a read burst. It drops that start only at the sampling point where `busy_o` is first seen low, so the start is present at the very edge that sends the last data word. The scoreboard then requires that no extra header appears, and the next real command is issued one cycle later and must be answered normally. A spurious start is also placed alongside the first write data word, and the check is that the write stream is unchanged.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_HI,
    S_RD_LO,
    S_RD_PACK,
    S_WR_WAIT,
    S_WR_HI,
    S_WR_LO
  } brx_state_e;

  localparam logic [2:0] TAG_RD_HDR = 3'b011;
  localparam logic [2:0] TAG_WR_ACK = 3'b010;

endpackage

// File: rtl/brx_cursor.sv
module brx_cursor #(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 8,
  parameter int NUM_REGS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              step2_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              hi_ok_o,
  output logic              lo_ok_o,
  output logic              lo_exists_o,
  output logic              last_pair_o
);

  localparam int CUR_W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 2;
  localparam int REM_W = CNT_W + 1;
  localparam logic [CUR_W-1:0] LIMIT = CUR_W'(NUM_REGS);

  logic [CUR_W-1:0] cur_q;
  logic [REM_W-1:0] rem_q;
  logic [CUR_W-1:0] cur_plus1;

  assign cur_plus1   = cur_q + CUR_W'(1);
  assign hi_ok_o     = (cur_q < LIMIT);
  assign lo_exists_o = (rem_q >= REM_W'(2));
  assign lo_ok_o     = lo_exists_o && (cur_plus1 < LIMIT);
  assign last_pair_o = (rem_q <= REM_W'(2));
  assign cur_addr_o  = cur_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      cur_q <= CUR_W'(load_addr_i);
      rem_q <= REM_W'(load_cnt_i) + REM_W'(1);
    end else if (step2_i) begin
      cur_q <= cur_q + CUR_W'(2);
      rem_q <= lo_exists_o ? (rem_q - REM_W'(2)) : '0;
    end
  end

  AST_STEP_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    step2_i |-> (rem_q != '0)); // R2

endmodule

// File: rtl/brx_pack.sv
module brx_pack #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_ok_i,
  input  logic                cap_hi_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [2*DATA_W-1:0] packed_o
);

  logic              ok_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] lo_sel;

  assign lo_sel   = ok_q ? rdata_i : '0;
  assign packed_o = {hi_q, lo_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q <= 1'b0;
      hi_q <= '0;
    end else begin
      ok_q <= rd_ok_i;
      if (cap_hi_i) hi_q <= ok_q ? rdata_i : '0;
    end
  end

endmodule

// File: rtl/brx_ctrl.sv
module brx_ctrl
  import brx_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_start_i,
  input  logic                cmd_write_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [CNT_W-1:0]    cmd_cnt_i,
  input  logic                wr_word_valid_i,
  input  logic [2*DATA_W-1:0] wr_word_i,
  input  logic [ADDR_W-1:0]   cur_addr_i,
  input  logic                hi_ok_i,
  input  logic                lo_ok_i,
  input  logic                lo_exists_i,
  input  logic                last_pair_i,
  input  logic [2*DATA_W-1:0] packed_i,
  output logic                load_o,
  output logic                step2_o,
  output logic                rd_ok_o,
  output logic                cap_hi_o,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_word_o,
  output logic [CNT_W-1:0]    frame_ext_o,
  output logic                busy_o,
  output logic                cmd_lock_o,
  output logic [ADDR_W-1:0]   rf_addr_o,
  output logic                rf_re_o,
  output logic                rf_we_o,
  output logic [DATA_W-1:0]   rf_wdata_o
);

  localparam int WORD_W = 2 * DATA_W;

  brx_state_e        state_q, state_n;
  logic [WORD_W-1:0] wbuf_q;
  logic              accept;
  logic [WORD_W-1:0] hdr_word, ack_word;

  assign accept   = (state_q == S_IDLE) && cmd_start_i;
  assign hdr_word = WORD_W'({TAG_RD_HDR, cmd_addr_i, cmd_cnt_i});
  assign ack_word = WORD_W'({TAG_WR_ACK, cmd_addr_i, cmd_cnt_i});
  assign load_o   = accept;
  assign busy_o   = (state_q != S_IDLE);
  assign cmd_lock_o = (state_q == S_RD_HI) || (state_q == S_RD_LO) ||
                      (state_q == S_RD_PACK);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_n = cmd_write_i ? S_WR_WAIT : S_RD_HI;
      S_RD_HI:   state_n = S_RD_LO;
      S_RD_LO:   state_n = S_RD_PACK;
      S_RD_PACK: state_n = last_pair_i ? S_IDLE : S_RD_HI;
      S_WR_WAIT: if (wr_word_valid_i) state_n = S_WR_HI;
      S_WR_HI:   state_n = lo_exists_i ? S_WR_LO : S_IDLE;
      S_WR_LO:   state_n = last_pair_i ? S_IDLE : S_WR_WAIT;
      default:   state_n = S_IDLE;
    endcase
  end

  always_comb begin
    rf_addr_o  = cur_addr_i;
    rf_re_o    = 1'b0;
    rf_we_o    = 1'b0;
    rf_wdata_o = '0;
    rd_ok_o    = 1'b0;
    cap_hi_o   = 1'b0;
    step2_o    = 1'b0;
    unique case (state_q)
      S_RD_HI: begin
        rf_re_o = hi_ok_i;
        rd_ok_o = hi_ok_i;
      end
      S_RD_LO: begin
        rf_addr_o = cur_addr_i + ADDR_W'(1);
        rf_re_o   = lo_ok_i;
        rd_ok_o   = lo_ok_i;
        cap_hi_o  = 1'b1;
      end
      S_RD_PACK: step2_o = 1'b1;
      S_WR_HI: begin
        rf_we_o    = hi_ok_i;
        rf_wdata_o = wbuf_q[WORD_W-1:DATA_W];
      end
      S_WR_LO: begin
        rf_addr_o  = cur_addr_i + ADDR_W'(1);
        rf_we_o    = lo_ok_i;
        rf_wdata_o = wbuf_q[DATA_W-1:0];
        step2_o    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_word_o  <= '0;
      frame_ext_o <= '0;
      wbuf_q      <= '0;
    end else begin
      state_q     <= state_n;
      rsp_valid_o <= 1'b0;
      if (state_n == S_IDLE) frame_ext_o <= '0;
      if (accept) begin
        rsp_valid_o <= 1'b1;
        rsp_word_o  <= cmd_write_i ? ack_word : hdr_word;
        frame_ext_o <= cmd_write_i ? (cmd_cnt_i >> 1) : '0;
      end else if (state_q == S_RD_PACK) begin
        rsp_valid_o <= 1'b1;
        rsp_word_o  <= packed_i;
      end
      if ((state_q == S_WR_WAIT) && wr_word_valid_i) wbuf_q <= wr_word_i;
    end
  end

  AST_HDR_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (accept && !cmd_write_i) |=> (rsp_valid_o && rsp_word_o[WORD_W-1 -: 3] == TAG_RD_HDR)); // R1
  AST_ACK_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_write_i) |=> (rsp_valid_o && rsp_word_o[WORD_W-1 -: 3] == TAG_WR_ACK)); // R6
  AST_LOCK_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_lock_o |-> busy_o); // R5
  AST_EXT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (frame_ext_o == '0)); // R7
  AST_RF_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_o && rf_re_o)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_o); // R12

endmodule

// File: rtl/brst_xfer_engine.sv
module brst_xfer_engine #(
  parameter int NUM_REGS = 20,
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_start_i,
  input  logic                cmd_write_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [CNT_W-1:0]    cmd_cnt_i,
  input  logic                wr_word_valid_i,
  input  logic [2*DATA_W-1:0] wr_word_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_word_o,
  output logic [CNT_W-1:0]    frame_ext_o,
  output logic                busy_o,
  output logic                cmd_lock_o,
  output logic [ADDR_W-1:0]   rf_addr_o,
  output logic                rf_re_o,
  output logic                rf_we_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  input  logic [DATA_W-1:0]   rf_rdata_i
);

  localparam int WORD_W = 2 * DATA_W;

  logic [ADDR_W-1:0] cur_addr;
  logic              hi_ok, lo_ok, lo_exists, last_pair;
  logic              load, step2, rd_ok, cap_hi;
  logic [WORD_W-1:0] packed_word;

  brx_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_REGS(NUM_REGS)) u_cursor (
    .clk(clk), .rst(rst),
    .load_i(load), .load_addr_i(cmd_addr_i), .load_cnt_i(cmd_cnt_i),
    .step2_i(step2),
    .cur_addr_o(cur_addr), .hi_ok_o(hi_ok), .lo_ok_o(lo_ok),
    .lo_exists_o(lo_exists), .last_pair_o(last_pair)
  );

  brx_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst(rst),
    .rd_ok_i(rd_ok), .cap_hi_i(cap_hi), .rdata_i(rf_rdata_i),
    .packed_o(packed_word)
  );

  brx_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_start_i(cmd_start_i), .cmd_write_i(cmd_write_i),
    .cmd_addr_i(cmd_addr_i), .cmd_cnt_i(cmd_cnt_i),
    .wr_word_valid_i(wr_word_valid_i), .wr_word_i(wr_word_i),
    .cur_addr_i(cur_addr), .hi_ok_i(hi_ok), .lo_ok_i(lo_ok),
    .lo_exists_i(lo_exists), .last_pair_i(last_pair),
    .packed_i(packed_word),
    .load_o(load), .step2_o(step2), .rd_ok_o(rd_ok), .cap_hi_o(cap_hi),
    .rsp_valid_o(rsp_valid_o), .rsp_word_o(rsp_word_o),
    .frame_ext_o(frame_ext_o), .busy_o(busy_o), .cmd_lock_o(cmd_lock_o),
    .rf_addr_o(rf_addr_o), .rf_re_o(rf_re_o), .rf_we_o(rf_we_o),
    .rf_wdata_o(rf_wdata_o)
  );

  AST_NO_OOR_WRITE: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (int'(rf_addr_o) < NUM_REGS)); // R10
  AST_NO_OOR_READ: assert property (@(posedge clk) disable iff (rst)
    rf_re_o |-> (int'(rf_addr_o) < NUM_REGS)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !(rf_we_o || rf_re_o)); // R11

endmodule

// File: tb/tb_brst_xfer_engine.sv
module tb_brst_xfer_engine;

  localparam int NREG = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_addr = '0;
  logic [7:0]  cmd_cnt = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_word = '0;
  logic        rsp_valid, busy, lock, rf_re, rf_we;
  logic [15:0] rsp_word;
  logic [7:0]  frame_ext, rf_wdata;
  logic [7:0]  rf_rdata = '0;
  logic [4:0]  rf_addr;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  rf_mem [0:31];
  logic [7:0]  shadow [0:31];
  logic [15:0] exp_rsp [$];
  string       rsp_tag [$];
  logic [12:0] exp_wr [$];
  string       wr_tag [$];

  always #4 clk = ~clk;

  brst_xfer_engine #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst(rst),
    .cmd_start_i(cmd_start), .cmd_write_i(cmd_write),
    .cmd_addr_i(cmd_addr), .cmd_cnt_i(cmd_cnt),
    .wr_word_valid_i(wr_valid), .wr_word_i(wr_word),
    .rsp_valid_o(rsp_valid), .rsp_word_o(rsp_word),
    .frame_ext_o(frame_ext), .busy_o(busy), .cmd_lock_o(lock),
    .rf_addr_o(rf_addr), .rf_re_o(rf_re), .rf_we_o(rf_we),
    .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
  );

  // register file model, one-cycle read latency
  always @(posedge clk) begin
    if (rf_we) rf_mem[rf_addr] <= rf_wdata;
    if (rf_re) rf_rdata <= rf_mem[rf_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (exp_rsp.size() == 0) chk(1'b0, "R5 unexpected response", int'(rsp_word), 0);
        else begin
          automatic logic [15:0] e = exp_rsp.pop_front();
          automatic string t = rsp_tag.pop_front();
          chk(rsp_word == e, t, int'(rsp_word), int'(e));
        end
      end
      if (rf_we) begin
        if (exp_wr.size() == 0) chk(1'b0, "R10 unexpected write", int'({rf_addr, rf_wdata}), 0);
        else begin
          automatic logic [12:0] e = exp_wr.pop_front();
          automatic string t = wr_tag.pop_front();
          chk({rf_addr, rf_wdata} == e, t, int'({rf_addr, rf_wdata}), int'(e));
        end
      end
      if (rf_re && int'(rf_addr) >= NREG) chk(1'b0, "R4 read issued out of range", int'(rf_addr), NREG);
    end
  end

  function automatic logic [7:0] rd_exp(int addr);
    return (addr < NREG) ? shadow[addr] : 8'h00;
  endfunction

  function automatic logic [15:0] wgen(int a, int k);
    return {8'(a * 7 + k * 13 + 1), 8'(a * 5 + k * 11 + 2)};
  endfunction

  task automatic pulse_start(input bit wr, input int a, input int n);
    cmd_start = 1'b1; cmd_write = wr; cmd_addr = 5'(a); cmd_cnt = 8'(n);
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic do_read(input int a, input int n);
    int nregs = n + 1;
    exp_rsp.push_back({3'b011, 5'(a), 8'(n)}); rsp_tag.push_back("R1 header");
    for (int k = 0; k < nregs; k += 2) begin
      automatic logic [7:0] hi = rd_exp(a + k);
      automatic logic [7:0] lo = (k + 1 < nregs) ? rd_exp(a + k + 1) : 8'h00;
      exp_rsp.push_back({hi, lo});
      if (k + 1 >= nregs) rsp_tag.push_back("R3 odd tail");
      else if (a + k + 1 >= NREG) rsp_tag.push_back("R4 zero fill");
      else rsp_tag.push_back("R2 data word");
    end
    pulse_start(1'b0, a, n);
    chk(lock == 1'b1, "R5 lock during read", int'(lock), 1);
    chk(busy == 1'b1, "R12 busy during read", int'(busy), 1);
    // spurious start held through the burst, including its last edge
    cmd_start = 1'b1; cmd_write = 1'b1; cmd_addr = 5'd2; cmd_cnt = 8'd3;
    while (busy) @(negedge clk);
    cmd_start = 1'b0;
    chk(lock == 1'b0, "R5 lock released", int'(lock), 0);
    chk(frame_ext == 8'd0, "R7 no extension on read", int'(frame_ext), 0);
  endtask

  task automatic do_write(input int a, input int n);
    int nregs = n + 1;
    exp_rsp.push_back({3'b010, 5'(a), 8'(n)}); rsp_tag.push_back("R6 ack");
    for (int k = 0; k < nregs; k += 2) begin
      automatic logic [15:0] w = wgen(a, k);
      if (a + k < NREG) begin
        exp_wr.push_back({5'(a + k), w[15:8]}); wr_tag.push_back("R8 upper byte");
        shadow[a + k] = w[15:8];
      end
      if (k + 1 < nregs && a + k + 1 < NREG) begin
        exp_wr.push_back({5'(a + k + 1), w[7:0]}); wr_tag.push_back("R8 lower byte");
        shadow[a + k + 1] = w[7:0];
      end
    end
    pulse_start(1'b1, a, n);
    chk(frame_ext == 8'(n >> 1), "R7 frame extension", int'(frame_ext), n >> 1);
    chk(lock == 1'b0, "R5 no lock on write", int'(lock), 0);
    for (int k = 0; k < nregs; k += 2) begin
      wr_valid = 1'b1; wr_word = wgen(a, k);
      if (k == 0) begin
        cmd_start = 1'b1; cmd_write = 1'b0; cmd_addr = 5'd0; cmd_cnt = 8'd1;
      end
      @(negedge clk);
      wr_valid = 1'b0; cmd_start = 1'b0;
      repeat (2) @(negedge clk);
    end
    while (busy) @(negedge clk);
    chk(frame_ext == 8'd0, "R7 extension cleared", int'(frame_ext), 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf_mem[i] = 8'(8'h40 + i * 3);
      shadow[i] = 8'(8'h40 + i * 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp_valid", int'(rsp_valid), 0);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(lock == 1'b0, "R11 lock", int'(lock), 0);
    chk(frame_ext == 8'd0, "R11 frame_ext", int'(frame_ext), 0);
    chk(!rf_we && !rf_re, "R11 rf strobes", int'({rf_we, rf_re}), 0);

    do_write(0, 7);     // R8 even count
    do_read(0, 7);      // R1 R2 read back
    do_write(9, 4);     // R9 odd count, reg 14 untouched
    do_read(13, 2);     // R9 reg 14 keeps old value
    do_read(3, 4);      // R3 odd read
    do_read(17, 5);     // R4 zero fill past range
    do_write(18, 3);    // R10 discard past range
    do_read(18, 3);
    do_read(31, 255);   // R4 whole burst out of range
    do_write(0, 0);     // single register write
    do_read(0, 0);      // single register read, R3
    do_read(0, 1);      // issued one cycle after previous end

    repeat (5) @(negedge clk);
    chk(exp_rsp.size() == 0, "R2 responses outstanding", exp_rsp.size(), 0);
    chk(exp_wr.size() == 0, "R8 writes outstanding", exp_wr.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule